// File: doc/BRIEF.md
# Analog Output Channel Mapper and Rescaler

This block feeds two banks of sixteen analog output converters from a set of serial sample streams. Up to eight streams arrive in parallel. Each stream delivers one word per valid cycle and marks its first word with a start-of-frame flag, so a word's position in the frame is its channel number. For every output, the block keeps the most recent word from one chosen stream and channel. The choice is free: any of the 1024 stream slots can drive any output.

A configuration port writes per-output settings: the source, a gain, an offset, a lower limit and an upper limit. On each sync pulse the block freezes the held samples and walks through the 32 outputs, one per cycle. For each output it converts the floating-point sample to signed 16-bit fixed point with 11 fractional bits, multiplies by the gain, adds the offset and clamps the result. When a bank's sixteen outputs have been refreshed, the block raises that bank's convert strobe for a single cycle. A bank that has never received configuration holds zeros and never strobes.

Top module: `aout_remap`

## Requirements
- R1: After reset every output word is 0, both convert strobes are 0 and both configured bits are 0.
- R2: A stream word with valid and start-of-frame set is channel 0, and each later valid word is the next channel. Words beyond channel 127 and words seen before the first start-of-frame are dropped. A channel 127 word therefore never lands on channel 0. Each output holds the latest word of its selected slot.
- R3: An input word is sign in bit 31, a biased-127 exponent in bits 30:23 and 23 fraction bits with an implied leading one. Input bits above bit 31 are ignored. An exponent of 0 converts to 0. The conversion to 16-bit with 11 fractional bits truncates toward zero, and an overflow saturates to 32767 or -32768.
- R4: A configuration word is laid out as output index [23:19], field [18:16] and value [15:0]. Field codes are 0 for the source, 1 for gain, 2 for offset, 3 for the lower limit and 4 for the upper limit. A source value carries the stream in [9:7] and the channel in [6:0]. Configuration words are ignored until the first word flagged start-of-frame.
- R5: Configured bit g turns 1 once an accepted configuration word addresses an output of bank g (outputs 16g to 16g+15), and it stays 1.
- R6: An output is trunc0(x·gain/2048) + offset, then clamped. Here x is the converted sample, the gain and offset share the output format, and trunc0 rounds toward zero. After reset the gain is 1.0 (2048), the offset is 0 and the limits are -32768 and 32767.
- R7: The clamp applies the upper limit first and the lower limit second, so the lower limit wins when it exceeds the upper limit.
- R8: Outputs change only during the pass that a sync pulse starts. The samples are frozen at the sync cycle, and a sync during a pass is ignored.
- R9: Convert strobe g pulses for exactly one cycle per pass, after all sixteen outputs of bank g hold their new values, and only when bank g is configured.
- R10: An output in an unconfigured bank stays 0 across sync pulses.
- R11: Any stream and channel can be routed to any output, including stream 7 channel 127 to output 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sync | input | 1 | Sample-time pulse that starts an update pass |
| cfg_valid | input | 1 | Configuration word present |
| cfg_sof | input | 1 | Configuration start-of-frame flag |
| cfg_word | input | 24 | Output index, field selector and value |
| s_valid | input | 8 | Per-stream word valid |
| s_sof | input | 8 | Per-stream start-of-frame flag |
| s_data | input | 272 | Per-stream words, 34 bits each, stream s at [34s+33:34s] |
| ch_out | output | 512 | Output words, output o at [16o+15:16o] |
| conv | output | 2 | Per-bank convert strobe |
| configured | output | 2 | Per-bank configured status |

## Verification
The bench builds the block with its defaults: eight streams of 128 channels, 32 outputs in banks of sixteen, and 34-bit stream words. With this build, the last slot (stream 7, channel 127) can be routed to the last output, and an over-long frame can be used to probe the channel counter at its wrap point. The two spare high word bits are driven to ones so that their exclusion from the conversion is visible. The two banks can be configured at different times, which brings the per-bank strobe and zero-hold behaviour within reach.

// File: rtl/aout_remap_pkg.sv
// Shared types and the float-to-fixed conversion for the output remapper.
// Assumes a 32-bit float word: sign, biased-127 exponent, 23 fraction bits.
package aout_remap_pkg;

    localparam int FX_W     = 16;
    localparam int FX_FRAC  = 11;
    localparam int FLD_W    = 3;

    typedef enum logic [FLD_W-1:0] {
        FLD_SRC  = 3'd0,
        FLD_GAIN = 3'd1,
        FLD_OFFS = 3'd2,
        FLD_LO   = 3'd3,
        FLD_HI   = 3'd4
    } fld_e;

    typedef struct packed {
        logic signed [FX_W-1:0] gain;
        logic signed [FX_W-1:0] offs;
        logic signed [FX_W-1:0] lo;
        logic signed [FX_W-1:0] hi;
    } coef_t;

    // Float to signed Q4.11: truncation toward zero, saturating on overflow.
    function automatic logic [FX_W-1:0] flt_to_fx(input logic [31:0] f);
        logic [7:0]  e;
        logic [23:0] sig;
        logic [23:0] mag;
        int          rsh;
        e   = f[30:23];
        sig = {1'b1, f[22:0]};
        rsh = 127 + 23 - FX_FRAC - int'(e);
        if (e == 8'd0)
            mag = '0;
        else if (rsh <= 0)
            mag = '1;
        else if (rsh >= 24)
            mag = '0;
        else
            mag = sig >> rsh;
        if (!f[31])
            return (mag > 24'd32767) ? 16'h7FFF : mag[15:0];
        else
            return (mag > 24'd32768) ? 16'h8000 : 16'(~mag[15:0] + 16'd1);
    endfunction

endpackage

// File: rtl/aout_remap_tap.sv
// Per-stream channel counter: the start-of-frame word is channel 0 and each
// later valid word takes the next number. Assumes at most CH_PER_STREAM words
// matter per frame; later words and words before any frame are dropped.
module aout_remap_tap #(
    parameter int CH_PER_STREAM = 128,
    parameter int CH_W          = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            valid,
    input  logic            sof,
    output logic            hit,
    output logic [CH_W-1:0] idx
);
    logic [CH_W:0] cnt;
    logic [CH_W:0] cur;

    // Channel number of the word on the inputs this cycle.
    always_comb begin
        cur = sof ? '0 : cnt;
        hit = valid && (cur < (CH_W+1)'(CH_PER_STREAM));
        idx = cur[CH_W-1:0];
    end

    // Advance the counter on each accepted word, parking at the frame end.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= (CH_W+1)'(CH_PER_STREAM);
        else if (hit)
            cnt <= cur + 1'b1;
    end

    assert_tap_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= (CH_W+1)'(CH_PER_STREAM));

endmodule

// File: rtl/aout_remap_cfg.sv
// Configuration register file: decodes index, field and value words, holds
// per-output source and coefficients, and tracks per-bank configured bits.
// Assumes words are ignored until the first start-of-frame word.
module aout_remap_cfg
    import aout_remap_pkg::*;
#(
    parameter int N_OUT      = 32,
    parameter int GROUP_SIZE = 16,
    parameter int N_GROUPS   = 2,
    parameter int OUT_IDX_W  = 5,
    parameter int STRM_W     = 3,
    parameter int CH_W       = 7,
    parameter int CFG_W      = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_valid,
    input  logic              cfg_sof,
    input  logic [CFG_W-1:0]  cfg_word,
    output coef_t             coef       [N_OUT],
    output logic [STRM_W-1:0] map_strm   [N_OUT],
    output logic [CH_W-1:0]   map_chan   [N_OUT],
    output logic [N_GROUPS-1:0] configured
);
    logic                 frame_open;
    logic                 accept;
    logic [OUT_IDX_W-1:0] w_idx;
    logic [FLD_W-1:0]     w_fld;
    logic [FX_W-1:0]      w_val;

    // Split the incoming word and decide whether it is taken.
    always_comb begin
        w_val  = cfg_word[FX_W-1:0];
        w_fld  = cfg_word[FX_W +: FLD_W];
        w_idx  = cfg_word[FX_W+FLD_W +: OUT_IDX_W];
        accept = cfg_valid && (cfg_sof || frame_open);
    end

    // Open the configuration stream at the first start-of-frame word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            frame_open <= 1'b0;
        else if (cfg_valid && cfg_sof)
            frame_open <= 1'b1;
    end

    for (genvar o = 0; o < N_OUT; o++) begin : g_out
        // Write the addressed field of output o.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                coef[o]     <= '{gain: 16'sh0800, offs: 16'sh0000,
                                 lo: 16'sh8000, hi: 16'sh7FFF};
                map_strm[o] <= '0;
                map_chan[o] <= '0;
            end else if (accept && w_idx == OUT_IDX_W'(o)) begin
                case (w_fld)
                    FLD_SRC: begin
                        map_strm[o] <= w_val[CH_W +: STRM_W];
                        map_chan[o] <= w_val[CH_W-1:0];
                    end
                    FLD_GAIN: coef[o].gain <= w_val;
                    FLD_OFFS: coef[o].offs <= w_val;
                    FLD_LO:   coef[o].lo   <= w_val;
                    FLD_HI:   coef[o].hi   <= w_val;
                    default: ;
                endcase
            end
        end
    end

    for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
        // Latch bank g as configured on its first accepted word.
        always_ff @(posedge clk) begin
            if (!rst_n)
                configured[g] <= 1'b0;
            else if (accept && (int'(w_idx) / GROUP_SIZE) == g)
                configured[g] <= 1'b1;
        end

        assert_cfg_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
            configured[g] |=> configured[g]);
    end

endmodule

// File: rtl/aout_remap_store.sv
// Sample holder: per output, captures the latest word of its selected stream
// slot and freezes a copy on request. Assumes only the low 32 word bits carry
// data; higher bits are dropped.
module aout_remap_store #(
    parameter int N_STREAMS = 8,
    parameter int N_OUT     = 32,
    parameter int WORD_W    = 34,
    parameter int STRM_W    = 3,
    parameter int CH_W      = 7
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_STREAMS-1:0]      s_hit,
    input  logic [CH_W-1:0]           s_idx    [N_STREAMS],
    input  logic [N_STREAMS*WORD_W-1:0] s_data,
    input  logic [STRM_W-1:0]         map_strm [N_OUT],
    input  logic [CH_W-1:0]           map_chan [N_OUT],
    input  logic                      take_snap,
    output logic [31:0]               snap     [N_OUT]
);
    logic [31:0] words [N_STREAMS];
    logic [31:0] live  [N_OUT];

    for (genvar s = 0; s < N_STREAMS; s++) begin : g_strm
        assign words[s] = s_data[s*WORD_W +: 32];
        if (WORD_W > 32) begin : g_spare
            logic unused_hi;
            assign unused_hi = ^s_data[s*WORD_W+32 +: WORD_W-32];
        end
    end

    for (genvar o = 0; o < N_OUT; o++) begin : g_out
        // Track the selected slot and freeze it when a pass starts.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                live[o] <= '0;
                snap[o] <= '0;
            end else begin
                if (s_hit[map_strm[o]] && s_idx[map_strm[o]] == map_chan[o])
                    live[o] <= words[map_strm[o]];
                if (take_snap)
                    snap[o] <= live[o];
            end
        end
    end

endmodule

// File: rtl/aout_remap_scale.sv
// Combinational rescaler: float to Q4.11, gain with truncation toward zero,
// offset, then upper and lower clamp (lower wins). Assumes gain, offset and
// limits share the output format.
module aout_remap_scale
    import aout_remap_pkg::*;
(
    input  logic [31:0]            word,
    input  coef_t                  coef,
    output logic signed [FX_W-1:0] y
);
    logic signed [31:0] x_w;
    logic signed [31:0] prod;
    logic signed [31:0] q;
    logic signed [31:0] s;
    logic signed [31:0] hi_w;
    logic signed [31:0] lo_w;
    logic signed [31:0] c;

    // Scale, shift with a bias for toward-zero rounding, offset and clamp.
    always_comb begin
        x_w  = 32'(signed'(flt_to_fx(word)));
        prod = x_w * 32'(coef.gain);
        q    = (prod + (prod[31] ? 32'sd2047 : 32'sd0)) >>> FX_FRAC;
        s    = q + 32'(coef.offs);
        hi_w = 32'(coef.hi);
        lo_w = 32'(coef.lo);
        c    = (s > hi_w) ? hi_w : s;
        c    = (c < lo_w) ? lo_w : c;
        y    = c[FX_W-1:0];
    end

endmodule

// File: rtl/aout_remap.sv
// Top of the analog output remapper: eight sample streams in, 32 rescaled
// outputs in banks of GROUP_SIZE out. A sync pulse freezes the held samples
// and refreshes one output per cycle; each configured bank then strobes.
// Assumes GROUP_SIZE divides N_OUT.
module aout_remap
    import aout_remap_pkg::*;
#(
    parameter int N_STREAMS     = 8,
    parameter int CH_PER_STREAM = 128,
    parameter int N_OUT         = 32,
    parameter int GROUP_SIZE    = 16,
    parameter int WORD_W        = 34,
    localparam int N_GROUPS     = N_OUT / GROUP_SIZE,
    localparam int OUT_IDX_W    = $clog2(N_OUT),
    localparam int CFG_W        = OUT_IDX_W + FLD_W + FX_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        sync,
    input  logic                        cfg_valid,
    input  logic                        cfg_sof,
    input  logic [CFG_W-1:0]            cfg_word,
    input  logic [N_STREAMS-1:0]        s_valid,
    input  logic [N_STREAMS-1:0]        s_sof,
    input  logic [N_STREAMS*WORD_W-1:0] s_data,
    output logic [N_OUT*FX_W-1:0]       ch_out,
    output logic [N_GROUPS-1:0]         conv,
    output logic [N_GROUPS-1:0]         configured
);
    localparam int STRM_W = (N_STREAMS > 1) ? $clog2(N_STREAMS) : 1;
    localparam int CH_W   = $clog2(CH_PER_STREAM);

    logic [N_STREAMS-1:0] s_hit;
    logic [CH_W-1:0]      s_idx    [N_STREAMS];
    coef_t                coef     [N_OUT];
    logic [STRM_W-1:0]    map_strm [N_OUT];
    logic [CH_W-1:0]      map_chan [N_OUT];
    logic [31:0]          snap     [N_OUT];
    logic                 busy;
    logic [OUT_IDX_W-1:0] idx;
    logic                 take_snap;
    logic signed [FX_W-1:0] y;
    logic [FX_W-1:0]      out_r    [N_OUT];

    for (genvar s = 0; s < N_STREAMS; s++) begin : g_tap
        aout_remap_tap #(.CH_PER_STREAM(CH_PER_STREAM), .CH_W(CH_W)) tap_i (
            .clk(clk), .rst_n(rst_n), .valid(s_valid[s]), .sof(s_sof[s]),
            .hit(s_hit[s]), .idx(s_idx[s]));
    end

    aout_remap_cfg #(.N_OUT(N_OUT), .GROUP_SIZE(GROUP_SIZE), .N_GROUPS(N_GROUPS),
        .OUT_IDX_W(OUT_IDX_W), .STRM_W(STRM_W), .CH_W(CH_W), .CFG_W(CFG_W)) cfg_i (
        .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_sof(cfg_sof),
        .cfg_word(cfg_word), .coef(coef), .map_strm(map_strm),
        .map_chan(map_chan), .configured(configured));

    aout_remap_store #(.N_STREAMS(N_STREAMS), .N_OUT(N_OUT), .WORD_W(WORD_W),
        .STRM_W(STRM_W), .CH_W(CH_W)) store_i (
        .clk(clk), .rst_n(rst_n), .s_hit(s_hit), .s_idx(s_idx), .s_data(s_data),
        .map_strm(map_strm), .map_chan(map_chan), .take_snap(take_snap),
        .snap(snap));

    aout_remap_scale scale_i (.word(snap[idx]), .coef(coef[idx]), .y(y));

    assign take_snap = sync && !busy;

    // Pass sequencer: one output per cycle from index 0 to N_OUT-1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            idx  <= '0;
        end else if (!busy) begin
            if (sync) begin
                busy <= 1'b1;
                idx  <= '0;
            end
        end else begin
            idx <= idx + 1'b1;
            if (idx == OUT_IDX_W'(N_OUT-1))
                busy <= 1'b0;
        end
    end

    for (genvar o = 0; o < N_OUT; o++) begin : g_out
        // Refresh output o in its slot of the pass when its bank is live.
        always_ff @(posedge clk) begin
            if (!rst_n)
                out_r[o] <= '0;
            else if (busy && idx == OUT_IDX_W'(o) && configured[o / GROUP_SIZE])
                out_r[o] <= y;
        end
        assign ch_out[o*FX_W +: FX_W] = out_r[o];
    end

    for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
        // Strobe bank g right after its last output was written.
        always_ff @(posedge clk) begin
            if (!rst_n)
                conv[g] <= 1'b0;
            else
                conv[g] <= busy && configured[g]
                        && idx == OUT_IDX_W'(g*GROUP_SIZE + GROUP_SIZE - 1);
        end

        assert_strobe_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
            conv[g] |=> !conv[g]);
        assert_strobe_configured_R9: assert property (@(posedge clk) disable iff (!rst_n)
            conv[g] |-> configured[g]);
        assert_unconf_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
            !configured[g] |-> ch_out[g*GROUP_SIZE*FX_W +: GROUP_SIZE*FX_W] == '0);
        assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !busy |=> $stable(ch_out[g*GROUP_SIZE*FX_W +: GROUP_SIZE*FX_W]));
    end

    assert_clamp_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $signed(coef[idx].lo) <= $signed(coef[idx].hi))
        |-> (y >= $signed(coef[idx].lo) && y <= $signed(coef[idx].hi)));

endmodule

// File: tb/aout_remap_tb_top.sv
// Directed bench for the analog output remapper, one task per scenario.
module aout_remap_tb_top;
    localparam int WW = 34;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sync = 1'b0;
    logic         cfg_valid = 1'b0;
    logic         cfg_sof = 1'b0;
    logic [23:0]  cfg_word = '0;
    logic [7:0]   s_valid = '0;
    logic [7:0]   s_sof = '0;
    logic [8*WW-1:0] s_data = '0;
    logic [511:0] ch_out;
    logic [1:0]   conv;
    logic [1:0]   configured;

    int nchk = 0;
    int nfail = 0;
    int nconv0 = 0;
    int nconv1 = 0;

    aout_remap dut_i (.clk(clk), .rst_n(rst_n), .sync(sync), .cfg_valid(cfg_valid),
        .cfg_sof(cfg_sof), .cfg_word(cfg_word), .s_valid(s_valid), .s_sof(s_sof),
        .s_data(s_data), .ch_out(ch_out), .conv(conv), .configured(configured));

    always #5 clk = ~clk;

    always @(negedge clk) begin
        if (conv[0]) nconv0++;
        if (conv[1]) nconv1++;
    end

    task automatic check(string tag, int act, int exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int outv(int o);
        return int'($signed(ch_out[o*16 +: 16]));
    endfunction

    // Reference: trunc toward zero of x*g/2048, plus offset, hi then lo clamp.
    function automatic int model(int x, int g, int off, int lo, int hi);
        int v;
        v = (x * g) / 2048 + off;
        if (v > hi) v = hi;
        if (v < lo) v = lo;
        return v;
    endfunction

    task automatic cfg(bit sof, int o, int fld, int val);
        @(negedge clk);
        cfg_valid = 1'b1;
        cfg_sof   = sof;
        cfg_word  = {5'(o), 3'(fld), 16'(val)};
        @(negedge clk);
        cfg_valid = 1'b0;
        cfg_sof   = 1'b0;
    endtask

    // Frame of n words on stream s; word ch carries w, the others fill.
    task automatic frame(int s, int n, int ch, logic [31:0] w, logic [31:0] fill);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            s_valid[s] = 1'b1;
            s_sof[s]   = (i == 0);
            s_data[s*WW +: WW] = {2'b11, (i == ch) ? w : fill};
        end
        @(negedge clk);
        s_valid[s] = 1'b0;
        s_sof[s]   = 1'b0;
    endtask

    task automatic pulse_sync();
        nconv0 = 0;
        nconv1 = 0;
        @(negedge clk);
        sync = 1'b1;
        @(negedge clk);
        sync = 1'b0;
        repeat (40) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 out0", outv(0), 0);
        check("R1 out31", outv(31), 0);
        check("R1 conv", int'(conv), 0);
        check("R1 configured", int'(configured), 0);
    endtask

    task automatic t_cfg_before_sof();
        cfg(1'b0, 0, 0, (2 << 7) | 5);
        frame(2, 6, 5, 32'h3F800000, 32'h0);
        pulse_sync();
        check("R4 ignored before sof", int'(configured), 0);
        check("R10 bank0 held zero", outv(0), 0);
        check("R9 no strobe unconfigured", nconv0 + nconv1, 0);
    endtask

    task automatic t_first_map();
        cfg(1'b1, 0, 0, (2 << 7) | 5);
        check("R5 bank0 configured", int'(configured[0]), 1);
        check("R5 bank1 not configured", int'(configured[1]), 0);
        frame(2, 6, 5, 32'h3F800000, 32'h0);
        pulse_sync();
        check("R3 R11 out0 one with spare bits set", outv(0), 2048);
        check("R9 bank0 strobe count", nconv0, 1);
        check("R9 bank1 no strobe", nconv1, 0);
        check("R10 out16 zero", outv(16), 0);
    endtask

    task automatic t_latest();
        frame(2, 6, 5, 32'h3F000000, 32'h0);
        frame(2, 6, 5, 32'hC0200000, 32'h0);
        check("R8 no change without sync", outv(0), 2048);
        pulse_sync();
        check("R2 latest word kept", outv(0), -5120);
    endtask

    task automatic t_gain_offset();
        cfg(1'b0, 0, 1, 16'h0400);
        cfg(1'b0, 0, 2, 256);
        pulse_sync();
        check("R6 gain and offset", outv(0), model(-5120, 1024, 256, -32768, 32767));
    endtask

    task automatic t_round();
        cfg(1'b0, 1, 0, 0);
        cfg(1'b0, 1, 1, 16'hFFFD);
        frame(0, 1, 0, 32'h3F000000, 32'h0);
        pulse_sync();
        check("R6 round toward zero", outv(1), model(1024, -3, 0, -32768, 32767));
    endtask

    task automatic t_sat_clamp();
        cfg(1'b0, 2, 0, (1 << 7) | 3);
        frame(1, 4, 3, 32'h42C80000, 32'h0);
        pulse_sync();
        check("R3 positive saturation", outv(2), 32767);
        frame(1, 4, 3, 32'hC2C80000, 32'h0);
        pulse_sync();
        check("R3 negative saturation", outv(2), -32768);
        cfg(1'b0, 2, 3, -1000);
        pulse_sync();
        check("R7 lower limit", outv(2), -1000);
        cfg(1'b0, 2, 4, 4096);
        frame(1, 4, 3, 32'h42C80000, 32'h0);
        pulse_sync();
        check("R7 upper limit", outv(2), 4096);
        cfg(1'b0, 2, 3, 500);
        cfg(1'b0, 2, 4, 100);
        pulse_sync();
        check("R7 lower wins over upper", outv(2), 500);
    endtask

    task automatic t_tiny();
        cfg(1'b0, 3, 0, (1 << 7) | 4);
        frame(1, 5, 4, 32'h358637BD, 32'h0);
        pulse_sync();
        check("R3 small value truncates to zero", outv(3), 0);
        frame(1, 5, 4, 32'h007FFFFF, 32'h0);
        pulse_sync();
        check("R3 zero exponent", outv(3), 0);
    endtask

    task automatic t_bank1();
        cfg(1'b0, 31, 0, (7 << 7) | 127);
        cfg(1'b0, 30, 0, (7 << 7) | 0);
        check("R5 bank1 configured", int'(configured[1]), 1);
        frame(7, 129, 0, 32'h3E800000, 32'h3F000000);
        pulse_sync();
        check("R11 stream7 ch127 to out31", outv(31), 1024);
        check("R2 word past ch127 dropped", outv(30), 512);
        check("R9 bank1 strobe count", nconv1, 1);
        check("R9 bank0 strobe count", nconv0, 1);
        nconv0 = 0;
        nconv1 = 0;
        repeat (50) @(negedge clk);
        check("R8 R9 no strobe without sync", nconv0 + nconv1, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cfg_before_sof();
        t_first_map();
        t_latest();
        t_gain_offset();
        t_round();
        t_sat_clamp();
        t_tiny();
        t_bank1();
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule